// File: doc/BRIEF.md
# Clarke Transform with Input-Mode Select

This block converts streaming phase samples into an orthogonal real/imaginary pair that a later rotation stage can consume. Each valid sample carries up to four signed Q1.15 values and a two-bit mode. The mode picks how the samples are read:

- a sine/cosine pair that already sits 90° apart and passes straight through;
- three phases spaced 120° apart, reduced to two orthogonal components;
- only the 120° and 240° phases, with the 0° phase rebuilt internally before the same reduction.

Results appear two clock cycles after the sample, flagged by a valid output. The block also provides a monitor copy of the pair that keeps the most recent result between samples. Intermediate sums carry extra headroom, and both outputs saturate to the Q1.15 range.

Top module: `clarke_mode_xform`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_vld`, `re`, `im`, `mon_re` and `mon_im` are all cleared to zero.
- R2: Every sample accepted with `in_vld` high yields exactly one `out_vld` pulse two rising edges later. Back-to-back samples give back-to-back results, and no result appears without a sample.
- R3: Mode 2'b00 passes the sample through: `re` = `ph_a` (cosine channel) and `im` = `ph_q` (sine channel). `ph_b` and `ph_c` have no effect.
- R4: Mode 2'b01 computes re = sat(floor(((2·ph_a − ph_b − ph_c)·10923 + 16384) / 32768)) and im = sat(floor(((ph_b − ph_c)·18919 + 16384) / 32768)). `ph_q` has no effect.
- R5: Mode 2'b10 replaces the 0° phase by −(ph_b + ph_c), formed at full width without wrap, and then applies the R4 formulas. `ph_a` and `ph_q` have no effect.
- R6: Mode 2'b11 behaves exactly as mode 2'b01.
- R7: Any result outside [−32768, 32767] is clamped to the nearest bound.
- R8: The mode is taken with each valid sample. Consecutive samples in different modes are each converted in their own mode.
- R9: `re` and `im` read zero in every cycle where `out_vld` is low.
- R10: `mon_re` and `mon_im` equal `re` and `im` whenever `out_vld` is high, and otherwise hold the last valid pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample valid |
| mode | input | 2 | Input format: 00 orthogonal, 01 three-phase, 10 two-wire three-phase, 11 as 01 |
| ph_a | input | 16 | 0° phase or cosine channel, Q1.15 |
| ph_b | input | 16 | 120° phase, Q1.15 |
| ph_c | input | 16 | 240° phase, Q1.15 |
| ph_q | input | 16 | Sine channel, Q1.15 |
| out_vld | output | 1 | Result valid |
| re | output | 16 | Real component, Q1.15, zero when idle |
| im | output | 16 | Imaginary component, Q1.15, zero when idle |
| mon_re | output | 16 | Held real component |
| mon_im | output | 16 | Held imaginary component |

## Verification
A corrupted first-stage register appears at the ports exactly two edges after the sample that loaded it. It can take three forms: a wrong value in `re`/`im`, a pass-through result where a conversion was expected, or a pulse missing from `out_vld`. The sweep runs every mode against a grid of extreme and mid-range values, changing the mode from sample to sample and driving junk on unused inputs. A mis-decoded mode, a dropped guard bit in the rebuilt phase, or a broken clamp therefore shows up in the first affected result. The idle cycles between bursts check that stale data never shows on the main outputs and that the monitor copy holds.

// File: rtl/clarke_mode_xform.sv
module clarke_mode_xform #(
  parameter int W       = 16,
  parameter int K_THIRD = 10923,
  parameter int K_ISQ3  = 18919
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic [1:0]          mode,
  input  logic signed [W-1:0] ph_a,
  input  logic signed [W-1:0] ph_b,
  input  logic signed [W-1:0] ph_c,
  input  logic signed [W-1:0] ph_q,
  output logic                out_vld,
  output logic signed [W-1:0] re,
  output logic signed [W-1:0] im,
  output logic signed [W-1:0] mon_re,
  output logic signed [W-1:0] mon_im
);
  localparam int SW = W + 3;
  localparam int PW = SW + W + 2;
  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (W - 2);

  function automatic logic signed [W-1:0] sat(input logic signed [PW-1:0] x);
    if (x > MAXV) return MAXV[W-1:0];
    if (x < MINV) return MINV[W-1:0];
    return x[W-1:0];
  endfunction

  logic signed [SW-1:0] ax, bx, cx, a_sel, dr, di;
  logic                 pass;

  assign ax = SW'(ph_a);
  assign bx = SW'(ph_b);
  assign cx = SW'(ph_c);

  always_comb begin
    pass  = 1'b0;
    a_sel = ax;
    case (mode)
      2'b00:   pass = 1'b1;
      2'b10:   a_sel = -(bx + cx);
      default: a_sel = ax;
    endcase
  end

  assign dr = (a_sel <<< 1) - bx - cx;
  assign di = bx - cx;

  logic                 v1, pass1;
  logic signed [SW-1:0] dr1, di1;
  logic signed [W-1:0]  p_re1, p_im1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      pass1 <= 1'b0;
      dr1   <= '0;
      di1   <= '0;
      p_re1 <= '0;
      p_im1 <= '0;
    end else begin
      v1 <= in_vld;
      if (in_vld) begin
        pass1 <= pass;
        dr1   <= dr;
        di1   <= di;
        p_re1 <= ph_a;
        p_im1 <= ph_q;
      end
    end
  end

  logic signed [PW-1:0] r_full, i_full;
  logic signed [W-1:0]  re_c, im_c;

  assign r_full = (PW'(dr1) * PW'(K_THIRD) + RND) >>> (W - 1);
  assign i_full = (PW'(di1) * PW'(K_ISQ3) + RND) >>> (W - 1);
  assign re_c   = pass1 ? p_re1 : sat(r_full);
  assign im_c   = pass1 ? p_im1 : sat(i_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      re      <= '0;
      im      <= '0;
      mon_re  <= '0;
      mon_im  <= '0;
    end else begin
      out_vld <= v1;
      re      <= v1 ? re_c : '0;
      im      <= v1 ? im_c : '0;
      if (v1) begin
        mon_re <= re_c;
        mon_im <= im_c;
      end
    end
  end
endmodule

module clarke_mode_xform_chk #(parameter int W = 16) (
  input logic                clk,
  input logic                rst,
  input logic                in_vld,
  input logic [1:0]          mode,
  input logic signed [W-1:0] ph_a,
  input logic signed [W-1:0] ph_q,
  input logic                v1,
  input logic                out_vld,
  input logic signed [W-1:0] re,
  input logic signed [W-1:0] im,
  input logic signed [W-1:0] mon_re,
  input logic signed [W-1:0] mon_im
);
  a_r2_first_stage: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> v1);
  a_r2_second_stage: assert property (@(posedge clk) disable iff (rst)
    v1 |=> out_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> !out_vld);
  a_r3_pass_through: assert property (@(posedge clk) disable iff (rst)
    (in_vld && mode == 2'b00) |=> ##1 (re == $past(ph_a, 2) && im == $past(ph_q, 2)));
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (re == '0 && im == '0));
  a_r10_mon_track: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (mon_re == re && mon_im == im));
  a_r10_mon_hold: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(mon_re) && $stable(mon_im)));
endmodule

bind clarke_mode_xform clarke_mode_xform_chk #(.W(W)) u_chk (.*);

// File: tb/clarke_mode_xform_test.sv
module clarke_mode_xform_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [1:0] mode = 2'b00;
  logic signed [15:0] ph_a = '0, ph_b = '0, ph_c = '0, ph_q = '0;
  logic out_vld;
  logic signed [15:0] re, im, mon_re, mon_im;

  clarke_mode_xform uut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  longint exp_re [0:4095];
  longint exp_im [0:4095];
  string  exp_tag [0:4095];
  int wr = 0, rd = 0;
  longint last_re = 0, last_im = 0;
  logic d1 = 0, d2 = 0;
  int cv [0:7] = '{-32768, -32767, -20000, -1, 0, 1, 16384, 32767};

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint clamp(longint x);
    return (x > 32767) ? 32767 : ((x < -32768) ? -32768 : x);
  endfunction

  always @(posedge clk) begin
    d1 <= rst ? 1'b0 : in_vld;
    d2 <= rst ? 1'b0 : d1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 out_vld", longint'(out_vld), longint'(d2));
      if (d2) begin
        check({exp_tag[rd], " re"}, longint'(re), exp_re[rd]);
        check({exp_tag[rd], " im"}, longint'(im), exp_im[rd]);
        last_re = exp_re[rd];
        last_im = exp_im[rd];
        rd++;
        check("R10 mon_re track", longint'(mon_re), last_re);
        check("R10 mon_im track", longint'(mon_im), last_im);
      end else begin
        check("R9 re idle", longint'(re), 0);
        check("R9 im idle", longint'(im), 0);
        check("R10 mon_re hold", longint'(mon_re), last_re);
        check("R10 mon_im hold", longint'(mon_im), last_im);
      end
    end
  end

  task automatic push(int md, int a, int b, int c, int q, bit chg);
    longint a0, dr, r, i;
    string tag;
    bit s;
    if (md == 0) begin
      r = a; i = q; tag = "R3"; s = 0;
    end else begin
      a0 = (md == 2) ? -(longint'(b) + c) : longint'(a);
      dr = 2 * a0 - b - c;
      r = (dr * 10923 + 16384) >>> 15;
      i = ((longint'(b) - c) * 18919 + 16384) >>> 15;
      s = (clamp(r) != r) || (clamp(i) != i);
      r = clamp(r);
      i = clamp(i);
      tag = (md == 2) ? "R5" : ((md == 3) ? "R6" : "R4");
    end
    if (s) tag = {tag, " R7"};
    if (chg) tag = {tag, " R8"};
    exp_re[wr] = r;
    exp_im[wr] = i;
    exp_tag[wr] = tag;
    wr++;
  endtask

  initial begin
    int prev_md;
    int cnt;
    prev_md = 0;
    cnt = 0;
    repeat (3) @(negedge clk);
    check("R1 out_vld", longint'(out_vld), 0);
    check("R1 re", longint'(re), 0);
    check("R1 im", longint'(im), 0);
    check("R1 mon_re", longint'(mon_re), 0);
    check("R1 mon_im", longint'(mon_im), 0);
    rst = 1'b0;
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 8; k++) begin
            int md, q;
            md = (m + k) & 3;
            q = cv[(j + k + 3) & 7];
            @(negedge clk);
            in_vld = 1'b1;
            mode = 2'(md);
            ph_a = 16'(cv[i]);
            ph_b = 16'(cv[j]);
            ph_c = 16'(cv[k]);
            ph_q = 16'(q);
            push(md, cv[i], cv[j], cv[k], q, md != prev_md);
            prev_md = md;
            cnt++;
            if (cnt % 7 == 0) begin
              @(negedge clk);
              in_vld = 1'b0;
              ph_a = 16'(cv[j]);
              ph_b = 16'(cv[k]);
              mode = 2'(~md);
            end
          end
    @(negedge clk);
    in_vld = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 all results seen", longint'(rd), longint'(wr));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule